// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small N-way set-associative data cache placed between a single processor request port and a word-wide backing-memory port. Each byte address is cut into a tag, a set index and a block offset. The block compares the tag against every way of the selected set at the same time. A hit completes in the same cycle. A miss raises a stall toward the requester while the controller writes back a dirty victim, if there is one, and then refills the whole block one word per beat.

Writes use a write-back policy with write-allocate. A write hit changes only the cached word and marks the line dirty. A write miss first brings the block into the cache and then performs the write as a hit. Replacement uses a small age counter per way. Age 0 marks the most recently used way. The way holding the largest age, WAYS-1, is the one to evict. With four ways this is a 2-bit counter, where 00 is newest and 11 is the victim.

The requester raises `cpu_req` and keeps the address, write enable and write data stable until a cycle in which `cpu_stall` is low. The access takes effect at the clock edge that ends that cycle.

Top module: `sa_cache`

## Requirements
- R1: With C = CACHE_BYTES, K = BLOCK_BYTES and N = WAYS, the cache has C/(K·N) sets. The set index is the address field just above the log2(K) offset bits. The tag is every bit above the index. Addresses that differ only in the tag compete for the N ways of one set.
- R2: After reset every line is invalid. A request hits only if a way of the selected set is valid and holds the request's tag. Otherwise `cpu_stall` is high in the first cycle of the request.
- R3: On a hit, `cpu_stall` is low and `cpu_hit` is high in the same cycle. On a read hit, `cpu_rdata` carries the addressed word, selected by the address bits just above the byte-within-word bits.
- R4: A write hit stores `cpu_wdata` into the cached word and sets the line's dirty bit. It makes no memory transfer.
- R5: On a miss, `cpu_stall` stays high until the block has been refilled. The refill reads K/(WORD_W/8) words, at ascending word addresses, starting at the block base. The request then completes as a hit, and the refilled line is valid and clean.
- R6: A write miss allocates the block through the refill of R5. It then writes the word into the cached line, which leaves the line dirty.
- R7: If the chosen victim is valid and dirty, its whole block is written to memory before any refill read starts. The write-back address is built from the stored tag and the set index, starting at the block base. A clean or invalid victim causes no write.
- R8: The victim is the lowest-numbered invalid way of the set, if there is one. Otherwise it is the way whose age equals WAYS-1.
- R9: After reset, way w of every set has age w. An access that hits sets that way's age to 0. Each other way in the set whose age was below the old age of that way gains one. As a result, the ages in a set are always a permutation of 0..WAYS-1.
- R10: A memory beat completes in a cycle where `mem_req` and `mem_ready` are both high. While waiting, the controller holds `mem_we`, `mem_addr` and `mem_wdata`. `mem_req` is low whenever no miss is being serviced.
- R11: In a 2-way configuration with 16-byte capacity and 4-byte blocks, the repeated address sequence 0, 8, 16 misses on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until stall is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address (word aligned) |
| cpu_wdata | input | WORD_W | Write data |
| cpu_rdata | output | WORD_W | Read data, valid when cpu_hit is high |
| cpu_hit | output | 1 | Request hits this cycle and completes at the next edge |
| cpu_stall | output | 1 | Request must be held |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Byte address of the beat's word |
| mem_wdata | output | WORD_W | Write-back word |
| mem_rdata | input | WORD_W | Refill word, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or delivers the beat this cycle |

## Verification
The bench keeps its own tag, dirty and age model and uses it to predict every hit, every victim and every write-back address. A wrong age update or an invalid-first rule that is ignored would therefore show up as an unexpected miss, a missing write-back, or a write-back to the wrong block. Random `mem_ready` gaps stress beat counting: a controller that advances on `mem_req` alone would move too few words, or the wrong words. Write hits are checked for silence on the memory port. The 0, 8, 16 replay on a 2-way instance catches replacement that is not strictly least-recently-used, which would produce a hit.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cache_state_e;

endpackage

// File: rtl/sa_cache_lookup.sv
module sa_cache_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/sa_cache_victim.sv
module sa_cache_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    output logic [WAY_W-1:0]           victim
);

    logic [WAY_W-1:0] oldest;
    logic [WAY_W-1:0] free_way;
    logic             any_free;

    always_comb begin
        oldest   = '0;
        free_way = '0;
        any_free = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages[w] == AGE_W'(WAYS - 1)) oldest = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
        victim = any_free ? free_way : oldest;
    end

endmodule

// File: rtl/sa_cache_age_upd.sv
module sa_cache_age_upd #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic [WAYS-1:0][AGE_W-1:0] ages_in,
    input  logic [WAY_W-1:0]           way,
    output logic [WAYS-1:0][AGE_W-1:0] ages_out
);

    logic [AGE_W-1:0] pivot;

    assign pivot = ages_in[way];

    always_comb begin
        for (int j = 0; j < WAYS; j++) begin
            if (WAY_W'(j) == way)
                ages_out[j] = '0;
            else if (ages_in[j] < pivot)
                ages_out[j] = ages_in[j] + AGE_W'(1);
            else
                ages_out[j] = ages_in[j];
        end
    end

endmodule

// File: rtl/sa_cache.sv
module sa_cache
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int WORD_W      = 32,
    parameter int BLOCK_BYTES = 16,
    parameter int WAYS        = 4,
    parameter int CACHE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WPB        = BLOCK_BYTES / WORD_BYTES;
    localparam int SETS       = CACHE_BYTES / (BLOCK_BYTES * WAYS);
    localparam int BYTE_OFF   = $clog2(WORD_BYTES);
    localparam int WSEL_W     = $clog2(WPB);
    localparam int OFF_W      = $clog2(BLOCK_BYTES);
    localparam int IDX_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int AGE_W      = WAY_W;

    typedef struct packed {
        cache_state_e                                  state;
        logic [WSEL_W-1:0]                             beat;
        logic [WAY_W-1:0]                              vway;
        logic [SETS-1:0][WAYS-1:0]                     valid;
        logic [SETS-1:0][WAYS-1:0]                     dirty;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]          age;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]          tag;
        logic [SETS-1:0][WAYS-1:0][WPB-1:0][WORD_W-1:0] data;
    } regs_t;

    function automatic regs_t reset_regs();
        regs_t r;
        r       = '0;
        r.state = ST_IDLE;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                r.age[s][w] = AGE_W'(w);
        return r;
    endfunction

    regs_t r_q, r_d;

    // address split
    logic [IDX_W-1:0]    req_idx;
    logic [TAG_W-1:0]    req_tag;
    logic [WSEL_W-1:0]   req_word;
    logic [BYTE_OFF-1:0] addr_unused;

    assign req_idx     = cpu_addr[OFF_W +: IDX_W];
    assign req_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_word    = cpu_addr[BYTE_OFF +: WSEL_W];
    assign addr_unused = cpu_addr[BYTE_OFF-1:0];

    logic                         lk_hit;
    logic [WAY_W-1:0]             lk_way;
    logic [WAY_W-1:0]             victim;
    logic [WAYS-1:0][AGE_W-1:0]   ages_new;

    sa_cache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .valid   (r_q.valid[req_idx]),
        .tags    (r_q.tag[req_idx]),
        .tag     (req_tag),
        .hit     (lk_hit),
        .hit_way (lk_way)
    );

    sa_cache_victim #(.WAYS(WAYS)) u_victim (
        .valid  (r_q.valid[req_idx]),
        .ages   (r_q.age[req_idx]),
        .victim (victim)
    );

    sa_cache_age_upd #(.WAYS(WAYS)) u_age (
        .ages_in  (r_q.age[req_idx]),
        .way      (lk_way),
        .ages_out (ages_new)
    );

    logic beat_last;
    logic fill_end;

    assign beat_last = (r_q.beat == WSEL_W'(WPB - 1));
    assign fill_end  = (r_q.state == ST_FILL) && mem_ready && beat_last;

    assign cpu_hit   = cpu_req && (r_q.state == ST_IDLE) && lk_hit;
    assign cpu_stall = cpu_req && !cpu_hit;
    assign cpu_rdata = r_q.data[req_idx][lk_way][req_word];

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lk_hit) begin
                        r_d.age[req_idx] = ages_new;
                        if (cpu_we) begin
                            r_d.data[req_idx][lk_way][req_word] = cpu_wdata;
                            r_d.dirty[req_idx][lk_way]          = 1'b1;
                        end
                    end else begin
                        r_d.vway = victim;
                        r_d.beat = '0;
                        if (r_q.valid[req_idx][victim] && r_q.dirty[req_idx][victim])
                            r_d.state = ST_WBACK;
                        else
                            r_d.state = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {r_q.tag[req_idx][r_q.vway], req_idx, r_q.beat,
                             {BYTE_OFF{1'b0}}};
                mem_wdata = r_q.data[req_idx][r_q.vway][r_q.beat];
                if (mem_ready) begin
                    r_d.beat = r_q.beat + WSEL_W'(1);
                    if (beat_last) r_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_idx, r_q.beat, {BYTE_OFF{1'b0}}};
                if (mem_ready) begin
                    r_d.data[req_idx][r_q.vway][r_q.beat] = mem_rdata;
                    r_d.beat = r_q.beat + WSEL_W'(1);
                    if (beat_last) begin
                        r_d.valid[req_idx][r_q.vway] = 1'b1;
                        r_d.dirty[req_idx][r_q.vway] = 1'b0;
                        r_d.tag[req_idx][r_q.vway]   = req_tag;
                        r_d.state                    = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= reset_regs();
        else        r_q <= r_d;
    end

    // ---------------- assertions ----------------
    logic [IDX_W-1:0] chk_idx_q;
    logic [WAY_W-1:0] chk_way_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_idx_q <= '0;
            chk_way_q <= '0;
        end else begin
            chk_idx_q <= req_idx;
            chk_way_q <= lk_way;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_age_chk
        logic [WAYS-1:0] seen;
        always_comb begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) seen[r_q.age[s][w]] = 1'b1;
        end
        assert_age_permutation_R9: assert property (@(posedge clk) disable iff (!rst_n)
            &seen);
    end

    assert_hit_age_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |=> (r_q.age[chk_idx_q][chk_way_q] == '0));

    assert_write_hit_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && cpu_we) |=> r_q.dirty[chk_idx_q][chk_way_q]);

    assert_fill_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_end |=> (r_q.valid[chk_idx_q][r_q.vway] && !r_q.dirty[chk_idx_q][r_q.vway]));

    assert_fill_then_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_end && cpu_req) |=> (cpu_req -> !cpu_stall));

    assert_wback_dirty_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WBACK) |-> (r_q.valid[req_idx][r_q.vway] && r_q.dirty[req_idx][r_q.vway]));

    assert_mem_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !mem_req);

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/sa_cache_test.sv
module sa_cache_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] init_a(input int i);
        return 32'(i) * 32'h9E37_79B1 + 32'h0000_5A5A;
    endfunction

    function automatic logic [15:0] init_b(input int i);
        return 16'(i) * 16'h03D1 + 16'h0077;
    endfunction

    // ---------------- large instance ----------------
    logic        a_req = 1'b0, a_we = 1'b0;
    logic [11:0] a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic        a_hit, a_stall;
    logic        a_mreq, a_mwe;
    logic [11:0] a_maddr;
    logic [31:0] a_mwdata, a_mrdata;
    logic        mem_ready = 1'b0;

    logic [31:0] mem_a [0:1023];
    logic [31:0] ref_a [0:1023];

    assign a_mrdata = mem_a[a_maddr[11:2]];

    sa_cache uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(a_req), .cpu_we(a_we), .cpu_addr(a_addr), .cpu_wdata(a_wdata),
        .cpu_rdata(a_rdata), .cpu_hit(a_hit), .cpu_stall(a_stall),
        .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr), .mem_wdata(a_mwdata),
        .mem_rdata(a_mrdata), .mem_ready(mem_ready)
    );

    // ---------------- small 2-way instance ----------------
    logic        b_req = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [15:0] b_rdata, b_mwdata, b_mrdata;
    logic        b_hit, b_stall, b_mreq, b_mwe;
    logic [7:0]  b_maddr;

    assign b_mrdata = init_b(int'(b_maddr[7:1]));

    sa_cache #(.ADDR_W(8), .WORD_W(16), .BLOCK_BYTES(4), .WAYS(2), .CACHE_BYTES(16)) uut_small (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(b_req), .cpu_we(1'b0), .cpu_addr(b_addr), .cpu_wdata(16'h0),
        .cpu_rdata(b_rdata), .cpu_hit(b_hit), .cpu_stall(b_stall),
        .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwdata),
        .mem_rdata(b_mrdata), .mem_ready(mem_ready)
    );

    // ---------------- memory side ----------------
    int          wb_cnt = 0, fill_cnt = 0, b_wb_cnt = 0;
    logic [11:0] wb_first, fill_first, fill_last;

    always @(negedge clk) mem_ready <= ($urandom_range(3) != 0);

    always @(posedge clk) begin
        if (a_mreq && mem_ready) begin
            if (a_mwe) begin
                mem_a[a_maddr[11:2]] <= a_mwdata;
                if (wb_cnt == 0) wb_first = a_maddr;
                wb_cnt++;
            end else begin
                if (fill_cnt == 0) fill_first = a_maddr;
                fill_last = a_maddr;
                fill_cnt++;
            end
        end
        if (b_mreq && b_mwe && mem_ready) b_wb_cnt++;
    end

    // ---------------- reference model of tags and ages ----------------
    bit m_valid [4][4];
    bit m_dirty [4][4];
    int m_tag   [4][4];
    int m_age   [4][4];

    task automatic access_a(input bit we, input logic [11:0] addr, input logic [31:0] wd);
        int idx, tg, wi, hw, vw, way, old;
        bit exp_wb;
        logic [11:0] wb_addr, blk;
        idx = int'(addr[5:4]);
        tg  = int'(addr[11:6]);
        wi  = int'(addr[11:2]);
        blk = {addr[11:4], 4'h0};
        hw = -1;
        vw = 0;
        exp_wb = 1'b0;
        wb_addr = '0;
        for (int w = 0; w < 4; w++) if (m_valid[idx][w] && m_tag[idx][w] == tg) hw = w;
        if (hw < 0) begin
            for (int w = 0; w < 4; w++) if (m_age[idx][w] == 3) vw = w;
            for (int w = 3; w >= 0; w--) if (!m_valid[idx][w]) vw = w;
            exp_wb  = m_valid[idx][vw] && m_dirty[idx][vw];
            wb_addr = {6'(m_tag[idx][vw]), 2'(idx), 4'h0};
        end
        @(negedge clk);
        a_req = 1'b1; a_we = we; a_addr = addr; a_wdata = wd;
        wb_cnt = 0; fill_cnt = 0;
        #1;
        if (hw < 0)
            chk(a_stall == 1'b1, we ? "R6 R1 R8 R9 miss" : "R2 R1 R8 R9 miss", a_stall, 1);
        else
            chk(a_stall == 1'b0 && a_hit == 1'b1, "R3 R1 R9 hit", a_stall, 0);
        while (a_stall) begin
            @(negedge clk);
            #1;
        end
        chk(a_hit == 1'b1, "R5 completes", a_hit, 1);
        if (!we) chk(a_rdata == ref_a[wi], "R3 read data", a_rdata, ref_a[wi]);
        if (hw < 0) begin
            chk(fill_cnt == 4, "R5 refill beats", fill_cnt, 4);
            chk(fill_first == blk, "R5 refill start", fill_first, blk);
            chk(fill_last == (blk | 12'h00C), "R10 refill order", fill_last, blk | 12'h00C);
            chk(wb_cnt == (exp_wb ? 4 : 0), "R7 write-back beats", wb_cnt, exp_wb ? 4 : 0);
            if (exp_wb) chk(wb_first == wb_addr, "R7 write-back address", wb_first, wb_addr);
        end
        @(posedge clk);
        #1;
        if (hw >= 0 && we)
            chk(wb_cnt == 0 && fill_cnt == 0 && a_mreq == 1'b0, "R4 no memory traffic", wb_cnt + fill_cnt, 0);
        way = (hw < 0) ? vw : hw;
        if (hw < 0) begin
            m_valid[idx][way] = 1'b1;
            m_tag[idx][way]   = tg;
            m_dirty[idx][way] = 1'b0;
        end
        old = m_age[idx][way];
        for (int j = 0; j < 4; j++) if (j != way && m_age[idx][j] < old) m_age[idx][j]++;
        m_age[idx][way] = 0;
        if (we) begin
            m_dirty[idx][way] = 1'b1;
            ref_a[wi] = wd;
        end
    endtask

    task automatic access_b(input logic [7:0] addr);
        @(negedge clk);
        b_req = 1'b1; b_addr = addr;
        #1;
        chk(b_stall == 1'b1, "R11 thrash miss", b_stall, 1);
        while (b_stall) begin
            @(negedge clk);
            #1;
        end
        chk(b_rdata == init_b(int'(addr[7:1])), "R11 thrash data", b_rdata, init_b(int'(addr[7:1])));
        @(posedge clk);
        #1;
        b_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) begin
            mem_a[i] = init_a(i);
            ref_a[i] = init_a(i);
        end
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 1'b0;
                m_dirty[s][w] = 1'b0;
                m_tag[s][w]   = 0;
                m_age[s][w]   = w;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(a_stall == 1'b0, "R2 reset no stall", a_stall, 0);
        chk(a_mreq == 1'b0 && b_mreq == 1'b0, "R10 reset memory idle", a_mreq, 0);

        // directed corner cases
        access_a(1'b0, 12'h000, 32'h0);          // cold miss, invalid way 0
        access_a(1'b0, 12'h004, 32'h0);          // same block hit
        access_a(1'b1, 12'h008, 32'hCAFE_0001);  // write hit, dirty
        access_a(1'b0, 12'h008, 32'h0);          // reads cached write
        access_a(1'b0, 12'h040, 32'h0);          // fill the other ways of set 0
        access_a(1'b0, 12'h080, 32'h0);
        access_a(1'b0, 12'h0C0, 32'h0);
        access_a(1'b0, 12'h010, 32'h0);          // set 1, no conflict with set 0
        access_a(1'b0, 12'h100, 32'h0);          // evicts dirty LRU block 0x000
        access_a(1'b0, 12'h000, 32'h0);          // write-back data came back
        access_a(1'b1, 12'h154, 32'hBEEF_0002);  // write miss allocate
        access_a(1'b0, 12'h154, 32'h0);

        // constrained random traffic
        for (int n = 0; n < 600; n++) begin
            logic [11:0] ad;
            ad = {3'b0, 3'($urandom_range(5)), 2'($urandom_range(3)), 2'($urandom_range(3)), 2'b00};
            access_a($urandom_range(9) < 4, ad, $urandom);
        end
        @(negedge clk);
        a_req = 1'b0;

        // LRU worst case on the 2-way instance
        for (int k = 0; k < 4; k++) begin
            access_b(8'd0);
            access_b(8'd8);
            access_b(8'd16);
        end
        chk(b_wb_cnt == 0, "R7 clean victims never written", b_wb_cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule